// File: doc/BRIEF.md
# Serial EEPROM I2C Target Engine

This block is the bus-facing half of a byte-addressed serial memory with a 17-bit address space. It watches an oversampled I2C clock and data line and recognizes START and STOP framing. It then checks the device select byte against a fixed family code and two strap inputs, and answers by pulling the data line low through an open-drain enable. The most significant address bit is carried in the device select byte. The two bytes that follow supply the rest of the address, upper byte first.

Write data is handed to a separate programming sequencer one byte at a time over a strobe interface, and a pulse marks the STOP that closes a write. Read data comes from a synchronous array port addressed by the engine's internal address counter. The sequencer reports an ongoing programming cycle on a busy input. While that input is high the engine ignores its own select byte, so a controller can poll for completion.

Top module: `eeprom_i2c_target`

## Requirements
- R1: A select byte whose bits [7:4] are 1010 and whose bits [3:2] equal strap_i[1:0] is acknowledged by pulling SDA low during the ninth clock. Any other select byte is not acknowledged, and the engine then ignores every bus bit until the next START.
- R2: While busy_i is high at the eighth rising SCL edge of a select byte, that byte is not acknowledged.
- R3: For a select byte with bit 0 equal to 0 (write), the next two bytes are acknowledged. Together with select bit 1 as address bit 16, they form the 17-bit address: the first byte gives bits 15:8 and the second gives bits 7:0.
- R4: Each data byte after the two address bytes is acknowledged and produces a one-cycle wr_strobe_o carrying the current address and the byte. The low 8 address bits then increment and wrap within the 256-byte page, and bits 16:8 stay unchanged.
- R5: A STOP after at least one data byte gives a one-cycle wr_done_o. A repeated START after the address bytes and before any data byte gives no strobe and no done pulse, and the loaded address becomes the start point of the following read.
- R6: A read command (select bit 0 equal to 1) starts at the internal counter, which holds the last accessed address plus one.
- R7: Each byte sent increments the counter. A controller acknowledge on the ninth clock brings the next byte, and the counter wraps from 0x1FFFF to 0x00000.
- R8: After a controller not-acknowledge the engine releases SDA and drives nothing until the next START.
- R9: sda_oe_o changes only while SCL is low, after a falling edge. Input bits are taken on rising SCL edges.
- R10: After reset sda_oe_o, wr_strobe_o and wr_done_o are low and rd_addr_o is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the bus |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_i | input | 1 | Serial clock line level |
| sda_i | input | 1 | Serial data line level (resolved bus) |
| strap_i | input | 2 | Pin-strapped select bits, compared with select bits [3:2] |
| busy_i | input | 1 | Programming cycle in progress |
| rd_data_i | input | 8 | Array read data, one cycle after rd_addr_o |
| sda_oe_o | output | 1 | 1 pulls SDA low |
| rd_addr_o | output | 17 | Internal address counter, read address to the array |
| wr_strobe_o | output | 1 | One-cycle pulse per received data byte |
| wr_addr_o | output | 17 | Address of the strobed byte |
| wr_data_o | output | 8 | Strobed data byte |
| wr_done_o | output | 1 | One-cycle pulse on a STOP that closes a write with data |

## Verification
A wrong phase or bit count shows at the ports within one byte time. The controller sees a missing or misplaced acknowledge on the very next ninth clock, or data bits that are shifted. A counter fault stays hidden until the next read or strobe, where the address or returned byte is wrong. For that reason every write is read back, and the page and full-range wrap points are each crossed once. An open-drain enable that moves while SCL is high would be taken as a false START or STOP by other devices. It is therefore watched on every system clock, not only at sample points.

// File: rtl/eet_pkg.sv
// Package: shared types for the serial EEPROM target engine.
// Assumes a byte-wide protocol with a 17-bit address fixed by the select-byte layout.
package eet_pkg;
    localparam int BYTE_W  = 8;
    localparam int ADDR_W  = 17;
    localparam int PAGE_W  = 8;
    localparam logic [3:0] FAMILY_CODE = 4'b1010;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RX,
        ST_ACK,
        ST_TX,
        ST_MACK
    } eng_state_t;

    typedef enum logic [2:0] {
        PH_SEL,
        PH_AHI,
        PH_ALO,
        PH_WDATA,
        PH_READ
    } eng_phase_t;
endpackage

// File: rtl/eet_bus_sync.sv
// Module: eet_bus_sync
// Brings SCL and SDA into the clock domain through a flop chain and derives
// clock edges plus START/STOP events from the synchronized levels.
// Assumes the bus idles high; the chain resets to 1 so no event fires at reset.
module eet_bus_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic sda_lvl,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_evt,
    output logic stop_evt
);
    localparam int TOP = STAGES - 1;

    logic [STAGES-1:0] scl_pipe;
    logic [STAGES-1:0] sda_pipe;
    logic              scl_q;
    logic              sda_q;

    genvar g;
    generate
        for (g = 0; g < STAGES; g++) begin : g_stage
            // Purpose: one synchronizer stage per line.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    scl_pipe[g] <= 1'b1;
                    sda_pipe[g] <= 1'b1;
                end else if (g == 0) begin
                    scl_pipe[g] <= scl_i;
                    sda_pipe[g] <= sda_i;
                end else begin
                    scl_pipe[g] <= scl_pipe[(g == 0) ? 0 : g - 1];
                    sda_pipe[g] <= sda_pipe[(g == 0) ? 0 : g - 1];
                end
            end
        end
    endgenerate

    // Purpose: hold previous synchronized levels for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl_pipe[TOP];
            sda_q <= sda_pipe[TOP];
        end
    end

    // Purpose: decode edges and framing events.
    always_comb begin
        sda_lvl   = sda_pipe[TOP];
        scl_rise  = scl_pipe[TOP] & ~scl_q;
        scl_fall  = ~scl_pipe[TOP] & scl_q;
        start_evt = scl_pipe[TOP] & scl_q & sda_q & ~sda_pipe[TOP];
        stop_evt  = scl_pipe[TOP] & scl_q & ~sda_q & sda_pipe[TOP];
    end
endmodule

// File: rtl/eet_addr_ctr.sv
// Module: eet_addr_ctr
// Internal address counter: parallel load, full-range increment (reads)
// and in-page increment that wraps the low PAGE_W bits (writes).
// Assumes at most one request per cycle matters; load has priority.
module eet_addr_ctr #(
    parameter int ADDR_W = 17,
    parameter int PAGE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [ADDR_W-1:0] load_val,
    input  logic              inc_full,
    input  logic              inc_page,
    output logic [ADDR_W-1:0] ctr_o
);
    localparam logic [PAGE_W-1:0] PAGE_ONE = PAGE_W'(1);

    // Purpose: update the counter according to the request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctr_o <= '0;
        end else if (load) begin
            ctr_o <= load_val;
        end else if (inc_full) begin
            ctr_o <= ctr_o + ADDR_W'(1);
        end else if (inc_page) begin
            ctr_o[PAGE_W-1:0] <= ctr_o[PAGE_W-1:0] + PAGE_ONE;
        end
    end

    // R4
    page_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (inc_page && !load && !inc_full) |=> (ctr_o[ADDR_W-1:PAGE_W] == $past(ctr_o[ADDR_W-1:PAGE_W])));

    // R7
    full_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (inc_full && !load && (&ctr_o)) |=> (ctr_o == '0));
endmodule

// File: rtl/eet_byte_engine.sv
// Module: eet_byte_engine
// Bit/byte sequencer: receives select, address and data bytes, drives the
// acknowledge and read data through the open-drain enable, and requests
// counter updates. Assumes bus events come from eet_bus_sync, one per cycle.
module eet_byte_engine
    import eet_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sda_lvl,
    input  logic              scl_rise,
    input  logic              scl_fall,
    input  logic              start_evt,
    input  logic              stop_evt,
    input  logic [1:0]        strap_i,
    input  logic              busy_i,
    input  logic [BYTE_W-1:0] rd_data_i,
    input  logic [ADDR_W-1:0] ctr_i,
    output logic              ctr_load,
    output logic [ADDR_W-1:0] ctr_load_val,
    output logic              ctr_inc_full,
    output logic              ctr_inc_page,
    output logic              sda_oe_o,
    output logic              wr_strobe_o,
    output logic [ADDR_W-1:0] wr_addr_o,
    output logic [BYTE_W-1:0] wr_data_o,
    output logic              wr_done_o
);
    localparam logic [3:0] LAST_BIT = 4'd7;
    localparam logic [3:0] ALL_BITS = 4'd8;

    eng_state_t        state;
    eng_phase_t        phase;
    logic [3:0]        bit_cnt;
    logic [BYTE_W-1:0] rx_sh;
    logic [BYTE_W-1:0] tx_sh;
    logic [BYTE_W-1:0] hi_byte;
    logic              page_bit;
    logic              ack_ok;
    logic              more;
    logic              wr_pending;

    logic [BYTE_W-1:0] rx_byte;
    logic              byte_done;
    logic              sel_match;
    logic              tx_load;

    // Purpose: combine the shift register with the current bit and decode requests.
    always_comb begin
        rx_byte      = {rx_sh[BYTE_W-2:0], sda_lvl};
        byte_done    = (state == ST_RX) && scl_rise && (bit_cnt == LAST_BIT);
        sel_match    = (rx_byte[7:4] == FAMILY_CODE) && (rx_byte[3:2] == strap_i);
        tx_load      = scl_fall && (((state == ST_ACK) && (phase == PH_READ)) ||
                                    ((state == ST_MACK) && more));
        ctr_load     = byte_done && (phase == PH_ALO);
        ctr_load_val = {page_bit, hi_byte, rx_byte};
        ctr_inc_page = byte_done && (phase == PH_WDATA);
        ctr_inc_full = tx_load;
    end

    // Purpose: protocol state machine and output registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state       <= ST_IDLE;
            phase       <= PH_SEL;
            bit_cnt     <= '0;
            rx_sh       <= '0;
            tx_sh       <= '0;
            hi_byte     <= '0;
            page_bit    <= 1'b0;
            ack_ok      <= 1'b0;
            more        <= 1'b0;
            wr_pending  <= 1'b0;
            sda_oe_o    <= 1'b0;
            wr_strobe_o <= 1'b0;
            wr_addr_o   <= '0;
            wr_data_o   <= '0;
            wr_done_o   <= 1'b0;
        end else begin
            wr_strobe_o <= 1'b0;
            wr_done_o   <= 1'b0;
            if (start_evt) begin
                state      <= ST_RX;
                phase      <= PH_SEL;
                bit_cnt    <= '0;
                sda_oe_o   <= 1'b0;
                wr_pending <= 1'b0;
            end else if (stop_evt) begin
                state      <= ST_IDLE;
                sda_oe_o   <= 1'b0;
                wr_done_o  <= wr_pending;
                wr_pending <= 1'b0;
            end else begin
                case (state)
                    ST_IDLE: begin
                        bit_cnt <= '0;
                    end
                    ST_RX: begin
                        if (scl_rise) begin
                            rx_sh   <= rx_byte;
                            bit_cnt <= bit_cnt + 4'd1;
                        end
                        if (byte_done) begin
                            case (phase)
                                PH_SEL: begin
                                    ack_ok   <= sel_match && !busy_i;
                                    page_bit <= rx_byte[1];
                                    phase    <= rx_byte[0] ? PH_READ : PH_AHI;
                                end
                                PH_AHI: begin
                                    hi_byte <= rx_byte;
                                    ack_ok  <= 1'b1;
                                    phase   <= PH_ALO;
                                end
                                PH_ALO: begin
                                    ack_ok <= 1'b1;
                                    phase  <= PH_WDATA;
                                end
                                PH_WDATA: begin
                                    ack_ok      <= 1'b1;
                                    wr_strobe_o <= 1'b1;
                                    wr_addr_o   <= ctr_i;
                                    wr_data_o   <= rx_byte;
                                    wr_pending  <= 1'b1;
                                end
                                default: begin
                                    ack_ok <= 1'b0;
                                end
                            endcase
                        end
                        if (scl_fall && (bit_cnt == ALL_BITS)) begin
                            if (ack_ok) begin
                                state    <= ST_ACK;
                                sda_oe_o <= 1'b1;
                            end else begin
                                state <= ST_IDLE;
                            end
                        end
                    end
                    ST_ACK: begin
                        if (tx_load) begin
                            tx_sh    <= rd_data_i;
                            sda_oe_o <= ~rd_data_i[BYTE_W-1];
                            bit_cnt  <= '0;
                            state    <= ST_TX;
                        end else if (scl_fall) begin
                            sda_oe_o <= 1'b0;
                            bit_cnt  <= '0;
                            state    <= ST_RX;
                        end
                    end
                    ST_TX: begin
                        if (scl_rise) begin
                            bit_cnt <= bit_cnt + 4'd1;
                        end
                        if (scl_fall) begin
                            if (bit_cnt == ALL_BITS) begin
                                sda_oe_o <= 1'b0;
                                state    <= ST_MACK;
                            end else begin
                                tx_sh    <= {tx_sh[BYTE_W-2:0], 1'b0};
                                sda_oe_o <= ~tx_sh[BYTE_W-2];
                            end
                        end
                    end
                    ST_MACK: begin
                        if (scl_rise) begin
                            more <= ~sda_lvl;
                        end
                        if (tx_load) begin
                            tx_sh    <= rd_data_i;
                            sda_oe_o <= ~rd_data_i[BYTE_W-1];
                            bit_cnt  <= '0;
                            state    <= ST_TX;
                        end else if (scl_fall) begin
                            state <= ST_IDLE;
                        end
                    end
                    default: begin
                        state <= ST_IDLE;
                    end
                endcase
            end
        end
    end

    // R9
    oe_timing_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sda_oe_o != $past(sda_oe_o)) |-> $past(scl_fall || start_evt || stop_evt));

    // R8
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE) |-> !sda_oe_o);

    // R4
    strobe_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_strobe_o |=> !wr_strobe_o);

    // R5
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_done_o |-> $past(stop_evt));
endmodule

// File: rtl/eeprom_i2c_target.sv
// Module: eeprom_i2c_target (top)
// I2C target front end for a 17-bit byte-addressed serial memory.
// Assumes the array answers rd_addr_o with rd_data_i one clock later and
// that the clock oversamples SCL by well over the synchronizer depth.
module eeprom_i2c_target
    import eet_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_i,
    input  logic              sda_i,
    input  logic [1:0]        strap_i,
    input  logic              busy_i,
    input  logic [BYTE_W-1:0] rd_data_i,
    output logic              sda_oe_o,
    output logic [ADDR_W-1:0] rd_addr_o,
    output logic              wr_strobe_o,
    output logic [ADDR_W-1:0] wr_addr_o,
    output logic [BYTE_W-1:0] wr_data_o,
    output logic              wr_done_o
);
    logic              sda_lvl;
    logic              scl_rise;
    logic              scl_fall;
    logic              start_evt;
    logic              stop_evt;
    logic              ctr_load;
    logic [ADDR_W-1:0] ctr_load_val;
    logic              ctr_inc_full;
    logic              ctr_inc_page;
    logic [ADDR_W-1:0] ctr;

    eet_bus_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_i     (scl_i),
        .sda_i     (sda_i),
        .sda_lvl   (sda_lvl),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_evt (start_evt),
        .stop_evt  (stop_evt)
    );

    eet_addr_ctr #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) u_ctr (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (ctr_load),
        .load_val (ctr_load_val),
        .inc_full (ctr_inc_full),
        .inc_page (ctr_inc_page),
        .ctr_o    (ctr)
    );

    eet_byte_engine u_eng (
        .clk          (clk),
        .rst_n        (rst_n),
        .sda_lvl      (sda_lvl),
        .scl_rise     (scl_rise),
        .scl_fall     (scl_fall),
        .start_evt    (start_evt),
        .stop_evt     (stop_evt),
        .strap_i      (strap_i),
        .busy_i       (busy_i),
        .rd_data_i    (rd_data_i),
        .ctr_i        (ctr),
        .ctr_load     (ctr_load),
        .ctr_load_val (ctr_load_val),
        .ctr_inc_full (ctr_inc_full),
        .ctr_inc_page (ctr_inc_page),
        .sda_oe_o     (sda_oe_o),
        .wr_strobe_o  (wr_strobe_o),
        .wr_addr_o    (wr_addr_o),
        .wr_data_o    (wr_data_o),
        .wr_done_o    (wr_done_o)
    );

    assign rd_addr_o = ctr;
endmodule

// File: tb/tb_eeprom_i2c_target.sv
module tb_eeprom_i2c_target;
    localparam logic [1:0] STRAP = 2'b10;
    localparam int HALF = 6;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        scl_drv = 1'b1;
    logic        sda_drv = 1'b1;
    logic        busy = 1'b0;
    logic [7:0]  rd_data;
    logic        sda_oe;
    logic [16:0] rd_addr;
    logic        wr_strobe;
    logic [16:0] wr_addr;
    logic [7:0]  wr_data;
    logic        wr_done;
    logic        sda_line;

    int checks = 0;
    int errors = 0;
    int st_cnt = 0;
    int done_cnt = 0;
    int oe_viol = 0;
    bit finished = 0;
    logic [16:0] st_addr [16];
    logic [7:0]  st_data [16];
    logic [7:0]  mem_q [int];
    logic        prev_oe = 1'b0;

    always #4 clk = ~clk;

    assign sda_line = sda_drv & ~sda_oe;

    eeprom_i2c_target dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .scl_i       (scl_drv),
        .sda_i       (sda_line),
        .strap_i     (STRAP),
        .busy_i      (busy),
        .rd_data_i   (rd_data),
        .sda_oe_o    (sda_oe),
        .rd_addr_o   (rd_addr),
        .wr_strobe_o (wr_strobe),
        .wr_addr_o   (wr_addr),
        .wr_data_o   (wr_data),
        .wr_done_o   (wr_done)
    );

    function automatic logic [7:0] init_val(input logic [16:0] a);
        return a[7:0] ^ a[15:8] ^ {a[16], 7'd0};
    endfunction

    function automatic logic [7:0] exp_mem(input logic [16:0] a);
        if (mem_q.exists(int'(a))) return mem_q[int'(a)];
        return init_val(a);
    endfunction

    // Array model, strobe log and R9 monitor
    always @(posedge clk) begin
        rd_data <= exp_mem(rd_addr);
        if (rst_n && wr_strobe) begin
            mem_q[int'(wr_addr)] = wr_data;
            st_addr[st_cnt & 15] = wr_addr;
            st_data[st_cnt & 15] = wr_data;
            st_cnt = st_cnt + 1;
        end
        if (rst_n && wr_done) done_cnt = done_cnt + 1;
        if (rst_n && (sda_oe != prev_oe) && scl_drv) oe_viol = oe_viol + 1;
        prev_oe <= sda_oe;
    end

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bit_cycle(input logic b, output logic s);
        wait_clk(HALF);
        sda_drv = b;
        wait_clk(HALF);
        scl_drv = 1'b1;
        wait_clk(HALF);
        s = sda_line;
        wait_clk(HALF);
        scl_drv = 1'b0;
    endtask

    task automatic bus_start;
        wait_clk(HALF);
        sda_drv = 1'b1;
        wait_clk(HALF);
        scl_drv = 1'b1;
        wait_clk(HALF);
        sda_drv = 1'b0;
        wait_clk(HALF);
        scl_drv = 1'b0;
    endtask

    task automatic bus_stop;
        wait_clk(HALF);
        sda_drv = 1'b0;
        wait_clk(HALF);
        scl_drv = 1'b1;
        wait_clk(HALF);
        sda_drv = 1'b1;
        wait_clk(2 * HALF);
    endtask

    task automatic send_byte(input logic [7:0] b, output logic ack);
        logic s;
        for (int i = 7; i >= 0; i--) bit_cycle(b[i], s);
        bit_cycle(1'b1, ack);
    endtask

    task automatic recv_byte(input bit mack, output logic [7:0] b);
        logic s;
        for (int i = 7; i >= 0; i--) begin
            bit_cycle(1'b1, s);
            b[i] = s;
        end
        bit_cycle(mack ? 1'b0 : 1'b1, s);
    endtask

    function automatic logic [7:0] sel(input logic a16, input logic rd);
        return {4'b1010, STRAP, a16, rd};
    endfunction

    task automatic do_write(input logic [16:0] a, input logic [7:0] d, output logic [3:0] acks);
        bus_start();
        send_byte(sel(a[16], 1'b0), acks[3]);
        send_byte(a[15:8], acks[2]);
        send_byte(a[7:0], acks[1]);
        send_byte(d, acks[0]);
        bus_stop();
    endtask

    task automatic set_addr(input logic [16:0] a, output logic [2:0] acks);
        bus_start();
        send_byte(sel(a[16], 1'b0), acks[2]);
        send_byte(a[15:8], acks[1]);
        send_byte(a[7:0], acks[0]);
    endtask

    localparam logic [24:0] VEC [4] = '{
        {17'h00010, 8'h5A},
        {17'h1A0FF, 8'hC3},
        {17'h10000, 8'h01},
        {17'h0ABCD, 8'hE7}
    };

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [3:0] acks4;
        logic [2:0] acks3;
        logic       ack;
        logic [7:0] b;
        int         base;
        int         dbase;

        wait_clk(5);
        // R10 reset state
        chk(sda_oe == 1'b0, "R10 oe", 32'(sda_oe), 0);
        chk(wr_strobe == 1'b0 && wr_done == 1'b0, "R10 strobes", 32'({wr_strobe, wr_done}), 0);
        chk(rd_addr == 17'd0, "R10 counter", 32'(rd_addr), 0);
        rst_n = 1'b1;
        wait_clk(10);

        // Table walk: R3 R4 R5 write then random read back
        for (int i = 0; i < 4; i++) begin
            base  = st_cnt;
            dbase = done_cnt;
            do_write(VEC[i][24:8], VEC[i][7:0], acks4);
            chk(acks4 == 4'b0000, "R3 write acks", 32'(acks4), 0);
            chk(st_cnt == base + 1 && st_addr[base & 15] == VEC[i][24:8] && st_data[base & 15] == VEC[i][7:0],
                "R4 strobe addr/data", {7'd0, st_addr[base & 15], st_data[base & 15]}, {7'd0, VEC[i]});
            chk(done_cnt == dbase + 1, "R5 done pulse", 32'(done_cnt - dbase), 1);
            set_addr(VEC[i][24:8], acks3);
            bus_start();
            send_byte(sel(1'b0, 1'b1), ack);
            recv_byte(1'b0, b);
            bus_stop();
            chk(acks3 == 3'b000 && ack == 1'b0 && b == VEC[i][7:0], "R5 random read back",
                {20'd0, acks3, ack, b}, {24'd0, VEC[i][7:0]});
        end

        // R1 strap mismatch, then ignored until START
        bus_start();
        send_byte({4'b1010, 2'b01, 2'b00}, ack);
        chk(ack == 1'b1, "R1 mismatch no ack", 32'(ack), 1);
        send_byte(sel(1'b0, 1'b0), ack);
        chk(ack == 1'b1, "R1 ignored until START", 32'(ack), 1);
        bus_stop();
        bus_start();
        send_byte({4'b1011, STRAP, 2'b00}, ack);
        chk(ack == 1'b1, "R1 wrong family code", 32'(ack), 1);
        bus_stop();

        // R2 busy blocks select acknowledge
        busy = 1'b1;
        bus_start();
        send_byte(sel(1'b0, 1'b1), ack);
        bus_stop();
        chk(ack == 1'b1, "R2 busy no ack", 32'(ack), 1);
        busy = 1'b0;
        bus_start();
        send_byte(sel(1'b0, 1'b0), ack);
        bus_stop();
        chk(ack == 1'b0, "R2 idle ack", 32'(ack), 0);

        // R4 page write wraps within the page
        base  = st_cnt;
        dbase = done_cnt;
        set_addr(17'h012FE, acks3);
        send_byte(8'h11, acks4[2]);
        send_byte(8'h22, acks4[1]);
        send_byte(8'h33, acks4[0]);
        bus_stop();
        chk(acks4[2:0] == 3'b000 && st_cnt == base + 3, "R4 page acks/strobes", 32'(st_cnt - base), 3);
        chk(st_addr[base & 15] == 17'h012FE && st_addr[(base + 1) & 15] == 17'h012FF &&
            st_addr[(base + 2) & 15] == 17'h01200, "R4 page wrap addr",
            32'(st_addr[(base + 2) & 15]), 32'h01200);
        chk(st_data[(base + 2) & 15] == 8'h33 && done_cnt == dbase + 1, "R4 page data",
            32'(st_data[(base + 2) & 15]), 32'h33);

        // R6 current address read continues after last access
        bus_start();
        send_byte(sel(1'b0, 1'b1), ack);
        recv_byte(1'b0, b);
        bus_stop();
        chk(ack == 1'b0 && b == exp_mem(17'h01201), "R6 current read", 32'(b), 32'(exp_mem(17'h01201)));

        // R5 repeated START abandons write; R7 sequential read across top
        base  = st_cnt;
        dbase = done_cnt;
        set_addr(17'h1FFFE, acks3);
        bus_start();
        send_byte(sel(1'b1, 1'b1), ack);
        recv_byte(1'b1, b);
        chk(b == exp_mem(17'h1FFFE), "R7 seq byte0", 32'(b), 32'(exp_mem(17'h1FFFE)));
        recv_byte(1'b1, b);
        chk(b == exp_mem(17'h1FFFF), "R7 seq byte1", 32'(b), 32'(exp_mem(17'h1FFFF)));
        recv_byte(1'b0, b);
        chk(b == exp_mem(17'h00000), "R7 seq wrap", 32'(b), 32'(exp_mem(17'h00000)));
        // R8 nothing driven after NACK
        begin
            int lows = 0;
            logic s;
            for (int k = 0; k < 9; k++) begin
                bit_cycle(1'b1, s);
                if (!s) lows++;
            end
            chk(lows == 0, "R8 released after nack", 32'(lows), 0);
        end
        bus_stop();
        chk(st_cnt == base && done_cnt == dbase, "R5 abandoned write", 32'(st_cnt - base), 0);

        // R7 counter after wrap
        bus_start();
        send_byte(sel(1'b0, 1'b1), ack);
        recv_byte(1'b0, b);
        bus_stop();
        chk(b == exp_mem(17'h00001), "R7 counter after wrap", 32'(b), 32'(exp_mem(17'h00001)));

        // R9 enable moved only while SCL low
        chk(oe_viol == 0, "R9 oe timing", 32'(oe_viol), 0);

        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule